// File: doc/BRIEF.md
# Iterative Add/Subtract Multiply-Divide Unit

This unit sits beside the integer ALU of a small pipelined processor and executes two long-running instructions. Multiplication is done by adding the first operand into an accumulator once for every unit of the second operand. Unsigned division is done by subtracting the divisor from a running remainder until the remainder drops below it, counting the subtractions. Latency therefore depends on the operand values rather than on a fixed schedule.

The execute stage presents two operands, a function code and a start strobe. When a recognised code is accepted, the unit latches everything it needs and raises a stall that holds the pipeline frozen until the results land in the Lo and Hi registers. Move-from-Lo/Hi instructions read those registers directly. A one-cycle done pulse marks the first cycle in which the new results are visible.

Top module: `itmd_unit`

## Requirements
- R1: With start_i high and the unit idle, func_i = 62 starts a multiply and func_i = 63 starts an unsigned divide; any other code is ignored: stall_o stays low, done_o stays low and Lo/Hi keep their values.
- R2: Both operands and the operation are latched in the accepting cycle; changes on opa_i, opb_i and func_i afterwards do not alter the result.
- R3: A multiply writes the low DW bits of opa_i × opb_i into Lo and leaves Hi unchanged.
- R4: A divide writes the unsigned quotient opa_i / opb_i into Lo and the remainder into Hi; a dividend below the divisor gives Lo = 0, Hi = dividend.
- R5: A divide by zero ends after a single working cycle with Lo = all ones and Hi = the dividend.
- R6: stall_o is high combinationally in the accepting cycle and stays high through every working cycle; the total stall length is opb_i + 2 cycles for a multiply and quotient + 2 cycles for a divide (2 for a divide by zero, 2 for a multiply by zero).
- R7: done_o is a single-cycle pulse in the first cycle after the stall in which Lo/Hi show the new results; stall_o is low in that cycle.
- R8: A start strobe that arrives while the unit is working is ignored and does not disturb the running operation.
- R9: After reset Lo and Hi read zero and stall_o and done_o are low; Lo/Hi change only when an operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe from the execute stage |
| func_i | input | FW | Function code of the instruction in execute |
| opa_i | input | DW | First operand (multiplicand / dividend) |
| opb_i | input | DW | Second operand (multiplier / divisor) |
| stall_o | output | 1 | Pipeline freeze request |
| done_o | output | 1 | One-cycle pulse when results commit |
| lo_o | output | DW | Lo register |
| hi_o | output | DW | Hi register |

## Verification
The sweep covers all small operand pairs in both operations, so a multiply by zero or a dividend below the divisor that took an extra iteration, or an off-by-one in the termination test, shows up as a wrong Lo/Hi value or a stall length off by one. Divide by zero is targeted because a design without its own exit would never drop stall and trip the run's guard. Operand lines are scrambled and a second start is pulsed mid-operation, which catches a datapath that reads live inputs instead of latched ones or a controller that restarts while busy. A wide multiply checks truncation to the low word and that Hi survives a multiply untouched.

// File: rtl/itmd_pkg.sv
package itmd_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_MUL  = 2'd1,
    OP_DIV  = 2'd2
  } itmd_op_e;
endpackage

// File: rtl/itmd_ctrl.sv
module itmd_ctrl
  import itmd_pkg::*;
#(
  parameter int FW       = 6,
  parameter int MUL_CODE = 62,
  parameter int DIV_CODE = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [FW-1:0] func_i,
  input  logic          fin_i,
  output logic          accept_o,
  output itmd_op_e      req_op_o,
  output itmd_op_e      op_o,
  output logic          busy_o,
  output logic          commit_o,
  output logic          stall_o,
  output logic          done_o
);
  localparam logic [FW-1:0] MulCode = FW'(MUL_CODE);
  localparam logic [FW-1:0] DivCode = FW'(DIV_CODE);

  itmd_op_e op_q, op_d;
  logic     busy_q, busy_d;
  logic     done_q, done_d;

  always_comb begin
    if (func_i == MulCode)      req_op_o = OP_MUL;
    else if (func_i == DivCode) req_op_o = OP_DIV;
    else                        req_op_o = OP_NONE;
  end

  assign accept_o = start_i && (req_op_o != OP_NONE) && !busy_q;
  assign commit_o = busy_q && fin_i;

  always_comb begin
    busy_d = busy_q;
    op_d   = op_q;
    if (accept_o) begin
      busy_d = 1'b1;
      op_d   = req_op_o;
    end else if (commit_o) begin
      busy_d = 1'b0;
    end
    done_d = commit_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (accept_o) op_q <= op_d;
    end
  end

  assign op_o    = op_q;
  assign busy_o  = busy_q;
  assign stall_o = busy_q || accept_o;
  assign done_o  = done_q;

  a_r6_stall_covers_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> stall_o);
  a_r7_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r7_done_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  a_r8_op_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !commit_o) |=> ($stable(op_q) && busy_q));
endmodule

// File: rtl/itmd_datapath.sv
module itmd_datapath
  import itmd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  itmd_op_e      req_op_i,
  input  itmd_op_e      op_i,
  input  logic          busy_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  output logic          fin_o,
  output logic [DW-1:0] lo_res_o,
  output logic [DW-1:0] hi_res_o
);
  localparam logic [DW-1:0] AllOnes = {DW{1'b1}};

  logic [DW-1:0] a_q, b_q, work_q, cnt_q;
  logic [DW-1:0] a_d, b_d, work_d, cnt_d;
  logic          step_en, ld_en;
  logic          b_zero;

  assign b_zero = (b_q == '0);

  always_comb begin
    if (op_i == OP_MUL) fin_o = (cnt_q == '0);
    else                fin_o = b_zero || (work_q < b_q);
  end

  assign step_en = busy_i && !fin_o;
  assign ld_en   = accept_i || step_en;

  always_comb begin
    a_d    = a_q;
    b_d    = b_q;
    work_d = work_q;
    cnt_d  = cnt_q;
    if (accept_i) begin
      a_d    = opa_i;
      b_d    = opb_i;
      work_d = (req_op_i == OP_DIV) ? opa_i : '0;
      cnt_d  = (req_op_i == OP_MUL) ? opb_i : '0;
    end else if (step_en) begin
      if (op_i == OP_MUL) begin
        work_d = work_q + a_q;
        cnt_d  = cnt_q - 1'b1;
      end else begin
        work_d = work_q - b_q;
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      work_q <= '0;
      cnt_q  <= '0;
    end else if (ld_en) begin
      a_q    <= a_d;
      b_q    <= b_d;
      work_q <= work_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    hi_res_o = work_q;
    if (op_i == OP_MUL)  lo_res_o = work_q;
    else if (b_zero)     lo_res_o = AllOnes;
    else                 lo_res_o = cnt_q;
  end

  a_r2_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !accept_i) |=> ($stable(a_q) && $stable(b_q)));
  a_r4_rem_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op_i == OP_DIV) |=> (work_q < $past(work_q)));
endmodule

// File: rtl/itmd_result.sv
module itmd_result
  import itmd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_i,
  input  itmd_op_e      op_i,
  input  logic [DW-1:0] lo_res_i,
  input  logic [DW-1:0] hi_res_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o
);
  logic [DW-1:0] lo_q, hi_q;
  logic          lo_en, hi_en;

  assign lo_en = commit_i;
  assign hi_en = commit_i && (op_i == OP_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_en) lo_q <= lo_res_i;
      if (hi_en) hi_q <= hi_res_i;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  a_r3_mul_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && op_i == OP_MUL) |=> $stable(hi_q));
  a_r9_quiet_between_ops: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/itmd_unit.sv
module itmd_unit
  import itmd_pkg::*;
#(
  parameter int DW       = 32,
  parameter int FW       = 6,
  parameter int MUL_CODE = 62,
  parameter int DIV_CODE = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [FW-1:0] func_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  output logic          stall_o,
  output logic          done_o,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o
);
  logic          accept, busy, commit, fin;
  itmd_op_e      req_op, op;
  logic [DW-1:0] lo_res, hi_res;

  itmd_ctrl #(.FW(FW), .MUL_CODE(MUL_CODE), .DIV_CODE(DIV_CODE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .func_i(func_i),
    .fin_i(fin), .accept_o(accept), .req_op_o(req_op), .op_o(op),
    .busy_o(busy), .commit_o(commit), .stall_o(stall_o), .done_o(done_o)
  );

  itmd_datapath #(.DW(DW)) dp_i (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .req_op_i(req_op),
    .op_i(op), .busy_i(busy), .opa_i(opa_i), .opb_i(opb_i),
    .fin_o(fin), .lo_res_o(lo_res), .hi_res_o(hi_res)
  );

  itmd_result #(.DW(DW)) res_i (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .op_i(op),
    .lo_res_i(lo_res), .hi_res_i(hi_res), .lo_o(lo_o), .hi_o(hi_o)
  );

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |-> !stall_o);
endmodule

// File: tb/itmd_unit_tb_top.sv
`timescale 1ns/1ps
module itmd_unit_tb_top;
  localparam int DW = 32;
  localparam int FW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [FW-1:0] func_i;
  logic [DW-1:0] opa_i, opb_i;
  logic          stall_o, done_o;
  logic [DW-1:0] lo_o, hi_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_lo = '0;
  logic [DW-1:0] exp_hi = '0;

  always #2.5 clk = ~clk;

  itmd_unit #(.DW(DW), .FW(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .func_i(func_i),
    .opa_i(opa_i), .opb_i(opb_i), .stall_o(stall_o), .done_o(done_o),
    .lo_o(lo_o), .hi_o(hi_o)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One operation: start in the current cycle, scramble inputs afterwards (R2),
  // pulse a second start while busy (R8), then check stall length and results.
  task automatic run_op(input logic is_div, input logic [DW-1:0] a, input logic [DW-1:0] b);
    int stalls;
    int guard;
    int exp_stalls;
    if (is_div) begin
      if (b == 0) begin
        exp_lo = '1; exp_hi = a; exp_stalls = 2;
      end else begin
        exp_lo = a / b; exp_hi = a % b; exp_stalls = int'(a / b) + 2;
      end
    end else begin
      exp_lo = a * b; exp_stalls = int'(b) + 2;
    end
    @(negedge clk);
    start_i = 1'b1; func_i = is_div ? 6'd63 : 6'd62; opa_i = a; opb_i = b;
    #1;
    stalls = 0;
    guard = 0;
    while (stall_o === 1'b1 && guard < 5000) begin
      stalls++;
      @(negedge clk);
      if (stalls == 1) begin
        // R8: restart attempt while busy, with other code and data
        start_i = 1'b1; func_i = is_div ? 6'd62 : 6'd63;
        opa_i = ~a; opb_i = b + 1;
      end else begin
        start_i = 1'b0; opa_i = a ^ 32'h5a5a_1234; opb_i = ~b;
      end
      #1;
      guard++;
    end
    check("R6 stall length", DW'(stalls), DW'(exp_stalls));
    check("R7 done pulse", DW'(done_o), 1);
    check(is_div ? "R4 divide Lo" : "R3 multiply Lo", lo_o, exp_lo);
    check(is_div ? "R4 divide Hi" : "R3 multiply keeps Hi", hi_o, exp_hi);
    start_i = 1'b0;
    @(negedge clk); #1;
    check("R7 done falls", DW'(done_o), 0);
    check("R9 Lo holds", lo_o, exp_lo);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; func_i = '0; opa_i = '0; opb_i = '0;
    #12;
    check("R9 reset Lo", lo_o, 0);
    check("R9 reset Hi", hi_o, 0);
    check("R9 reset stall", DW'(stall_o), 0);
    check("R9 reset done", DW'(done_o), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        run_op(1'b0, DW'(a), DW'(b));
        run_op(1'b1, DW'(a), DW'(b));
      end

    // R5: divide by zero with a large dividend
    run_op(1'b1, 32'hdead_beef, 32'd0);
    // R3: truncation to the low word, Hi untouched by multiply
    run_op(1'b0, 32'hffff_ffff, 32'd3);
    run_op(1'b0, 32'h0012_3457, 32'd300);
    // R4: long divide and dividend below divisor
    run_op(1'b1, 32'd1000, 32'd7);
    run_op(1'b1, 32'd5, 32'hffff_0000);

    // R1: unrecognised codes are ignored
    for (int f = 0; f < 62; f += 7) begin
      @(negedge clk);
      start_i = 1'b1; func_i = FW'(f); opa_i = 32'd9; opb_i = 32'd4;
      #1;
      check("R1 no stall on other code", DW'(stall_o), 0);
      @(negedge clk); start_i = 1'b0; #1;
      check("R1 no done on other code", DW'(done_o), 0);
      check("R1 Lo unchanged", lo_o, exp_lo);
      check("R1 Hi unchanged", hi_o, exp_hi);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule